// File: doc/BRIEF.md
# Navigation Frame Sync Detector

This block finds the start of navigation subframes in a stream of demodulated data bits. Bits arrive one per strobe, each with the value of the external bit-epoch counter, which counts bit positions within a 300-bit subframe. On every strobe the block looks at the newest 60 bits as a telemetry word followed by a handover word, plus the two bits sent just before them. It accepts the window only when the preamble, the subframe ID, the two trailing zero bits of the handover word and the parity of both words are all correct.

Once a window is accepted, the block compares the epoch counter with the value it must hold at the last bit of the handover word. If the two agree while hunting, frame sync is declared at once. If they disagree, the block sends a one-cycle slew command that loads the expected value into the external counter. It then waits for the next accepted window, which comes one subframe later, and declares sync if the counter agrees there. The decoded subframe ID of the latest accepted window is always available at the output.

Top module: `nav_frame_sync`

## Requirements
- R1: While reset is asserted and in the first cycle after it, frame_sync and slew_en are 0 and sf_id is 0.
- R2: Outputs change only in the cycle after a clock edge where bit_valid is 1. Activity on bit_in with bit_valid low has no effect. A window is formed from the newest 62 accepted bits: the two bits before the telemetry word, then the 30 telemetry bits, then the 30 handover bits, with bit 1 of each word received first.
- R3: The decoded telemetry bits 1 to 8 must equal 10001011, with bit 1 first. A decoded bit is the received bit XOR the last bit (bit 30) of the preceding word.
- R4: The decoded handover bits 20, 21, 22 form the subframe ID, bit 20 most significant. The ID must lie in 1 to 5.
- R5: The received bits 29 and 30 of the handover word must both be 0.
- R6: Both words must pass 6-bit parity. Let p29 and p30 be bits 29 and 30 of the preceding word, and d1..d24 the decoded data bits. Then bit25 = p29^d1^d2^d3^d5^d6^d10^d11^d12^d13^d14^d17^d18^d20^d23, bit26 = p30^d2^d3^d4^d6^d7^d11^d12^d13^d14^d15^d18^d19^d21^d24, bit27 = p29^d1^d3^d4^d5^d7^d8^d12^d13^d14^d15^d16^d19^d20^d22, bit28 = p30^d2^d4^d5^d6^d8^d9^d13^d14^d15^d16^d17^d20^d21^d23, bit29 = p30^d1^d3^d5^d6^d7^d9^d10^d14^d15^d16^d17^d18^d21^d22^d24, and bit30 = p29^d3^d5^d6^d8^d9^d10^d11^d13^d15^d19^d22^d23^d24.
- R7: While hunting, an accepted window with epoch_cnt equal to 10 at its strobe raises frame_sync in the next cycle.
- R8: While hunting, an accepted window with any other epoch_cnt produces slew_en high for exactly the next cycle, with slew_value equal to 10. frame_sync stays 0, and the block waits for confirmation.
- R9: While waiting for confirmation, an accepted window with epoch_cnt equal to 10 raises frame_sync. An accepted window with any other epoch_cnt issues another slew.
- R10: Once frame_sync is 1 it stays 1 until reset, and slew_en stays 0.
- R11: In the cycle after any accepted window, sf_id holds that window's decoded subframe ID, whatever the sync state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe: bit_in and epoch_cnt are valid this cycle |
| bit_in | input | 1 | Demodulated data bit |
| epoch_cnt | input | 9 | Bit position within the subframe (0 to 299) |
| frame_sync | output | 1 | Frame synchronisation declared |
| slew_en | output | 1 | One-cycle command to load slew_value into the epoch counter |
| slew_value | output | 9 | Value the epoch counter must take |
| sf_id | output | 3 | Subframe ID of the latest accepted window |

## Verification
The bench builds the block with its default parameters: 30-bit words, a 300-bit subframe, an expected epoch of 10 and IDs 1 to 5. At this size, a slew followed by 240 filler bits lines the counter up with the next subframe. Both the confirmation path and a repeated slew are therefore reached within a few thousand cycles. Because the word length is 30, the bench can build real parity-correct words, including handover words whose last two bits are solved to zero or deliberately set to one. This lets each rejection condition be tested on its own.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

   typedef enum logic [1:0] {
      NFS_HUNT = 2'd0,
      NFS_PEND = 2'd1,
      NFS_LOCK = 2'd2
   } nfs_state_e;

   // w[31] = bit 29 of previous word, w[30] = bit 30 of previous word,
   // w[30-k] = received bit k of this word (k = 1..30)
   function automatic logic word_parity_ok(input logic [31:0] w);
      logic        p29;
      logic        p30;
      logic [24:1] d;
      logic [30:25] p;
      p29 = w[31];
      p30 = w[30];
      for (int k = 1; k <= 24; k++) d[k] = w[30-k] ^ p30;
      p[25] = p29 ^ d[1] ^ d[2] ^ d[3] ^ d[5] ^ d[6] ^ d[10] ^ d[11] ^ d[12]
                  ^ d[13] ^ d[14] ^ d[17] ^ d[18] ^ d[20] ^ d[23];
      p[26] = p30 ^ d[2] ^ d[3] ^ d[4] ^ d[6] ^ d[7] ^ d[11] ^ d[12] ^ d[13]
                  ^ d[14] ^ d[15] ^ d[18] ^ d[19] ^ d[21] ^ d[24];
      p[27] = p29 ^ d[1] ^ d[3] ^ d[4] ^ d[5] ^ d[7] ^ d[8] ^ d[12] ^ d[13]
                  ^ d[14] ^ d[15] ^ d[16] ^ d[19] ^ d[20] ^ d[22];
      p[28] = p30 ^ d[2] ^ d[4] ^ d[5] ^ d[6] ^ d[8] ^ d[9] ^ d[13] ^ d[14]
                  ^ d[15] ^ d[16] ^ d[17] ^ d[20] ^ d[21] ^ d[23];
      p[29] = p30 ^ d[1] ^ d[3] ^ d[5] ^ d[6] ^ d[7] ^ d[9] ^ d[10] ^ d[14]
                  ^ d[15] ^ d[16] ^ d[17] ^ d[18] ^ d[21] ^ d[22] ^ d[24];
      p[30] = p29 ^ d[3] ^ d[5] ^ d[6] ^ d[8] ^ d[9] ^ d[10] ^ d[11] ^ d[13]
                  ^ d[15] ^ d[19] ^ d[22] ^ d[23] ^ d[24];
      return p == {w[0], w[1], w[2], w[3], w[4], w[5]};
   endfunction

endpackage

// File: rtl/nfs_window.sv
module nfs_window #(
   parameter int DEPTH = 62
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   output logic [DEPTH-1:0] win_nxt
);

   logic [DEPTH-2:0] win_q;

   assign win_nxt = {win_q, bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        win_q <= '0;
      else if (shift_en) win_q <= win_nxt[DEPTH-2:0];
   end

endmodule

// File: rtl/nfs_word_check.sv
module nfs_word_check #(
   parameter int WORD_LEN = 30
) (
   input  logic [WORD_LEN+1:0] word_ext,
   output logic                parity_ok
);

   if (WORD_LEN != 30) begin : g_bad_len
      $error("nfs_word_check: parity equations are defined for 30-bit words");
   end

   assign parity_ok = nfs_pkg::word_parity_ok(word_ext);

endmodule

// File: rtl/nfs_ctrl.sv
module nfs_ctrl #(
   parameter int EPW          = 9,
   parameter int ID_W         = 3,
   parameter int EPOCH_AT_HOW = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strobe,
   input  logic            win_ok,
   input  logic [EPW-1:0]  epoch,
   input  logic [ID_W-1:0] id_in,
   output logic            frame_sync,
   output logic            slew_en,
   output logic [EPW-1:0]  slew_value,
   output logic [ID_W-1:0] sf_id
);
   import nfs_pkg::*;

   localparam logic [EPW-1:0] EXPECT = EPW'(EPOCH_AT_HOW);

   nfs_state_e st_q;

   assign frame_sync = (st_q == NFS_LOCK);
   assign slew_value = EXPECT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= NFS_HUNT;
         slew_en <= 1'b0;
         sf_id   <= '0;
      end else begin
         slew_en <= 1'b0;
         if (strobe && win_ok) begin
            sf_id <= id_in;
            if (st_q != NFS_LOCK) begin
               if (epoch == EXPECT) begin
                  st_q <= NFS_LOCK;
               end else begin
                  st_q    <= NFS_PEND;
                  slew_en <= 1'b1;
               end
            end
         end
      end
   end

   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> (!slew_en && $stable(sf_id) && $stable(frame_sync)));

   p_sync_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_sync) |-> ($past(strobe) && $past(epoch) == EXPECT));

   p_slew_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      slew_en |-> ($past(strobe) && $past(epoch) != EXPECT && !frame_sync));

   p_sync_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> (frame_sync && !slew_en));

endmodule

// File: rtl/nav_frame_sync.sv
module nav_frame_sync #(
   parameter int             WORD_LEN     = 30,
   parameter int             NUM_WORDS    = 2,
   parameter int             SUBFRAME_LEN = 300,
   parameter int             EPOCH_AT_HOW = 10,
   parameter int             PRE_LEN      = 8,
   parameter logic [7:0]     PREAMBLE     = 8'b1000_1011,
   parameter int             ID_W         = 3,
   parameter int             ID_FIRST_BIT = 20,
   parameter int             ID_MIN       = 1,
   parameter int             ID_MAX       = 5,
   localparam int            EPW          = $clog2(SUBFRAME_LEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_valid,
   input  logic            bit_in,
   input  logic [EPW-1:0]  epoch_cnt,
   output logic            frame_sync,
   output logic            slew_en,
   output logic [EPW-1:0]  slew_value,
   output logic [ID_W-1:0] sf_id
);

   localparam int WIN_LEN  = NUM_WORDS * WORD_LEN + 2;
   localparam int TLM_B1   = WIN_LEN - 3;           // index of telemetry bit 1
   localparam int TLM_P30  = WIN_LEN - 2;           // bit 30 before telemetry
   localparam int HOW_P30  = WORD_LEN;              // telemetry bit 30
   localparam int ID_HI    = WORD_LEN - ID_FIRST_BIT;

   if (NUM_WORDS != 2) begin : g_bad_words
      $error("nav_frame_sync: window must hold exactly two words");
   end
   if (PRE_LEN != 8) begin : g_bad_pre
      $error("nav_frame_sync: preamble length must be 8");
   end
   if (EPOCH_AT_HOW >= SUBFRAME_LEN) begin : g_bad_epoch
      $error("nav_frame_sync: expected epoch outside subframe");
   end
   if (ID_FIRST_BIT + ID_W > WORD_LEN - 6) begin : g_bad_id
      $error("nav_frame_sync: ID field overlaps parity");
   end

   logic [WIN_LEN-1:0]   win_nxt;
   logic [NUM_WORDS-1:0] par_ok;
   logic [PRE_LEN-1:0]   pre_dec;
   logic [ID_W-1:0]      id_dec;
   logic                 pre_ok;
   logic                 id_ok;
   logic                 zero_ok;
   logic                 win_ok;

   nfs_window #(.DEPTH(WIN_LEN)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (bit_valid),
      .bit_in   (bit_in),
      .win_nxt  (win_nxt)
   );

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      nfs_word_check #(.WORD_LEN(WORD_LEN)) u_chk (
         .word_ext  (win_nxt[(NUM_WORDS-g)*WORD_LEN+1 -: WORD_LEN+2]),
         .parity_ok (par_ok[g])
      );
   end

   assign pre_dec = win_nxt[TLM_B1 -: PRE_LEN] ^ {PRE_LEN{win_nxt[TLM_P30]}};
   assign id_dec  = win_nxt[ID_HI -: ID_W]     ^ {ID_W{win_nxt[HOW_P30]}};
   assign pre_ok  = (pre_dec == PREAMBLE);
   assign id_ok   = (id_dec >= ID_W'(ID_MIN)) && (id_dec <= ID_W'(ID_MAX));
   assign zero_ok = (win_nxt[1:0] == 2'b00);
   assign win_ok  = pre_ok && id_ok && zero_ok && (&par_ok);

   nfs_ctrl #(
      .EPW          (EPW),
      .ID_W         (ID_W),
      .EPOCH_AT_HOW (EPOCH_AT_HOW)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (bit_valid),
      .win_ok     (win_ok),
      .epoch      (epoch_cnt),
      .id_in      (id_dec),
      .frame_sync (frame_sync),
      .slew_en    (slew_en),
      .slew_value (slew_value),
      .sf_id      (sf_id)
   );

   p_id_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_id != '0) |-> (sf_id >= ID_W'(ID_MIN) && sf_id <= ID_W'(ID_MAX)));

   p_id_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_id != $past(sf_id)) |-> $past(bit_valid));

endmodule

// File: tb/sim_nav_frame_sync.sv
module sim_nav_frame_sync;

   localparam int CLK_PERIOD = 10;
   localparam int SF         = 300;
   localparam int EPW        = $clog2(SF);
   localparam int EXPECT     = 10;
   localparam logic [7:0] PRE = 8'b1000_1011;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bit_valid = 1'b0;
   logic           bit_in = 1'b0;
   logic [EPW-1:0] epoch_cnt = '0;
   logic           frame_sync;
   logic           slew_en;
   logic [EPW-1:0] slew_value;
   logic [2:0]     sf_id;

   int checks = 0;
   int errors = 0;

   // reference model state
   bit       hist[$];
   int       m_st;      // 0 hunt, 1 waiting, 2 locked
   bit       exp_slew;
   bit [2:0] m_id;
   int       ep;
   bit       slew_seen;

   nav_frame_sync u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_valid  (bit_valid),
      .bit_in     (bit_in),
      .epoch_cnt  (epoch_cnt),
      .frame_sync (frame_sync),
      .slew_en    (slew_en),
      .slew_value (slew_value),
      .sf_id      (sf_id)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD*200000);
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      errors++;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit in_eq(input int j, input int k);
      case (j)
         25: return k inside {1,2,3,5,6,10,11,12,13,14,17,18,20,23};
         26: return k inside {2,3,4,6,7,11,12,13,14,15,18,19,21,24};
         27: return k inside {1,3,4,5,7,8,12,13,14,15,16,19,20,22};
         28: return k inside {2,4,5,6,8,9,13,14,15,16,17,20,21,23};
         29: return k inside {1,3,5,6,7,9,10,14,15,16,17,18,21,22,24};
         default: return k inside {3,5,6,8,9,10,11,13,15,19,22,23,24};
      endcase
   endfunction

   function automatic logic [30:1] encode(input logic [24:1] d, input bit p29, input bit p30);
      logic [30:1] w;
      for (int k = 1; k <= 24; k++) w[k] = d[k] ^ p30;
      for (int j = 25; j <= 30; j++) begin
         bit acc;
         acc = (j == 25 || j == 27 || j == 30) ? p29 : p30;
         for (int k = 1; k <= 24; k++) if (in_eq(j, k)) acc = acc ^ d[k];
         w[j] = acc;
      end
      return w;
   endfunction

   // hist[base], hist[base+1] are the previous word's bits 29, 30
   function automatic bit word_ok(input int base);
      logic [30:1] w;
      logic [24:1] d;
      for (int k = 1; k <= 30; k++) w[k] = hist[base+1+k];
      for (int k = 1; k <= 24; k++) d[k] = w[k] ^ hist[base+1];
      return encode(d, hist[base], hist[base+1]) == w;
   endfunction

   task automatic eval(output bit ok, output bit [2:0] id);
      bit [7:0] p;
      for (int k = 1; k <= 8; k++) p[8-k] = hist[1+k] ^ hist[1];
      for (int k = 0; k < 3; k++) id[2-k] = hist[31+20+k] ^ hist[31];
      ok = (p == PRE) && (id >= 1) && (id <= 5) && !hist[60] && !hist[61]
           && word_ok(0) && word_ok(30);
   endtask

   task automatic compare();
      check("R10", "frame_sync", int'(frame_sync), (m_st == 2) ? 1 : 0);
      check("R8",  "slew_en",    int'(slew_en),    int'(exp_slew));
      check("R11", "sf_id",      int'(sf_id),      int'(m_id));
   endtask

   task automatic step(input bit v, input bit b);
      bit       nx_slew;
      bit       ok;
      bit [2:0] id;
      bit_valid = v;
      bit_in    = b;
      epoch_cnt = EPW'(ep);
      nx_slew   = 1'b0;
      if (v && rst_n) begin
         hist.push_back(b);
         void'(hist.pop_front());
         eval(ok, id);
         if (ok) begin
            m_id = id;
            if (m_st != 2) begin
               if (ep == EXPECT) m_st = 2;
               else begin
                  nx_slew = 1'b1;
                  m_st    = 1;
               end
            end
         end
      end
      @(posedge clk);
      #(CLK_PERIOD/2);
      exp_slew = nx_slew;
      compare();
      if (slew_en) slew_seen = 1'b1;
   endtask

   task automatic send_bit(input bit b);
      step(1'b1, b);
      if (exp_slew) ep = (EXPECT + 1) % SF;
      else          ep = (ep + 1) % SF;
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
   endtask

   task automatic send_random(input int n);
      for (int i = 0; i < n; i++) send_bit(1'($urandom % 2));
   endtask

   task automatic model_reset();
      hist.delete();
      for (int i = 0; i < 62; i++) hist.push_back(1'b0);
      m_st     = 0;
      m_id     = 3'd0;
      exp_slew = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
      rst_n = 1'b1;
      step(1'b0, 1'b0);
   endtask

   // zb: required {bit29,bit30} of handover word; corrupt 1 = telemetry parity,
   // 2 = handover parity; end_ep < 0 keeps the running count; pause > 0 idles
   // with bit_in toggling before the last bit
   task automatic send_frame(input logic [7:0] pre, input int id, input int zb,
                             input int corrupt, input int end_ep, input int pause);
      logic [24:1] d;
      logic [30:1] w;
      bit          p29, p30;
      bit          found;
      if (end_ep >= 0) ep = (end_ep - 59 + SF) % SF;
      slew_seen = 1'b0;
      p29 = hist[60];
      p30 = hist[61];
      for (int k = 1; k <= 24; k++) d[k] = 1'($urandom % 2);
      for (int k = 1; k <= 8; k++) d[k] = pre[8-k];
      w = encode(d, p29, p30);
      if (corrupt == 1) w[25] = ~w[25];
      for (int k = 1; k <= 30; k++) send_bit(w[k]);
      p29 = w[29];
      p30 = w[30];
      for (int k = 1; k <= 24; k++) d[k] = 1'($urandom % 2);
      d[20] = id[2];
      d[21] = id[1];
      d[22] = id[0];
      found = 1'b0;
      for (int c = 0; c < 4; c++) begin
         if (!found) begin
            d[23] = c[1];
            d[24] = c[0];
            w = encode(d, p29, p30);
            if ({w[29], w[30]} == zb[1:0]) found = 1'b1;
         end
      end
      if (corrupt == 2) w[26] = ~w[26];
      for (int k = 1; k <= 29; k++) send_bit(w[k]);
      if (pause > 0) begin
         for (int i = 0; i < pause; i++) step(1'b0, 1'(i % 2));
         check("R2", "frame_sync during idle pause", int'(frame_sync), 0);
      end
      send_bit(w[30]);
   endtask

   initial begin
      model_reset();
      ep        = 0;
      slew_seen = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
      check("R1", "frame_sync in reset", int'(frame_sync), 0);
      check("R1", "slew_en in reset",    int'(slew_en),    0);
      check("R1", "sf_id in reset",      int'(sf_id),      0);
      rst_n = 1'b1;
      step(1'b0, 1'b0);
      check("R1", "frame_sync after reset", int'(frame_sync), 0);

      send_random(70);

      send_frame(8'b1000_1010, 2, 0, 0, EXPECT, 0);
      check("R3", "sync after wrong preamble", int'(frame_sync), 0);
      check("R3", "slew after wrong preamble", int'(slew_seen), 0);
      send_frame(PRE, 0, 0, 0, EXPECT, 0);
      check("R4", "sync with ID 0", int'(frame_sync), 0);
      send_frame(PRE, 6, 0, 0, EXPECT, 0);
      check("R4", "sync with ID 6", int'(frame_sync), 0);
      send_frame(PRE, 2, 2, 0, EXPECT, 0);
      check("R5", "sync with bit 29 set", int'(frame_sync), 0);
      check("R5", "slew with bit 29 set", int'(slew_seen), 0);
      send_frame(PRE, 2, 0, 1, EXPECT, 0);
      check("R6", "sync with telemetry parity error", int'(frame_sync), 0);
      send_frame(PRE, 2, 0, 2, EXPECT, 0);
      check("R6", "sync with handover parity error", int'(frame_sync), 0);

      send_frame(PRE, 3, 0, 0, 200, 0);
      check("R8", "slew on epoch mismatch", int'(slew_seen), 1);
      check("R8", "slew_value", int'(slew_value), EXPECT);
      check("R8", "no sync on mismatch", int'(frame_sync), 0);
      check("R11", "sf_id after mismatch window", int'(sf_id), 3);

      send_frame(PRE, 4, 0, 0, -1, 0);
      check("R9", "second slew while waiting", int'(slew_seen), 1);
      check("R9", "no sync while waiting", int'(frame_sync), 0);
      send_random(240);
      check("R9", "no sync before confirmation", int'(frame_sync), 0);
      send_frame(PRE, 1, 0, 0, -1, 0);
      check("R9", "sync confirmed one subframe later", int'(frame_sync), 1);
      check("R9", "no slew at confirmation", int'(slew_seen), 0);

      send_frame(PRE, 5, 0, 0, 123, 0);
      check("R10", "sync held on later mismatch", int'(frame_sync), 1);
      check("R10", "no slew while locked", int'(slew_seen), 0);
      check("R11", "sf_id updated while locked", int'(sf_id), 5);

      do_reset();
      check("R1", "frame_sync after second reset", int'(frame_sync), 0);
      check("R1", "sf_id after second reset", int'(sf_id), 0);
      send_random(20);
      send_frame(PRE, 2, 0, 0, EXPECT, 7);
      check("R7", "immediate sync on matching epoch", int'(frame_sync), 1);
      check("R7", "no slew on matching epoch", int'(slew_seen), 0);
      check("R11", "sf_id on direct sync", int'(sf_id), 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule